// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Classic Status Flags

This block is the arithmetic and logic unit for the accumulator instructions of a classic 8-bit processor core. Each cycle it takes an operation code, two operands, an incoming carry and the current status byte. In the same cycle it returns the 8-bit result, the updated status byte, and a strobe that tells the register file whether the result is to be written back. It holds no state. Instruction sequencing, operand fetch and decimal-mode arithmetic belong to the surrounding core.

A small decoder turns the operation code into a struct of strobes. The strobes select the adder input, the carry source, the result multiplexer leg and the way each flag is formed. A datapath module acts on those strobes. The bits of the status byte are fixed: C is bit 0, Z bit 1, I bit 2, D bit 3, B bit 4, the unused bit 5, V bit 6 and N bit 7.

Top module: `alu8_core`

## Requirements
- R1: Op 0 (add) returns A + B + carryIn modulo 256. C is bit 8 of the sum. V is set when A and B have the same sign and the result's sign differs from A. Z and N follow the result. Write-back is asserted.
- R2: Op 1 (subtract) returns A − B − (1 − carryIn) modulo 256. C is set when no borrow occurs. V is set when A and B differ in sign and the result's sign differs from A. Z and N follow the result. Write-back is asserted.
- R3: Op 2 (compare) sets C when A ≥ B and sets Z and N from the 8-bit value A − B. V is unchanged and write-back is deasserted.
- R4: Op 6 (bit test) sets Z when (A AND B) is zero and copies B bit 7 into N and B bit 6 into V. C is unchanged and write-back is deasserted.
- R5: Ops 3, 4 and 5 (AND, OR, XOR of A with B) write back the result and update only Z and N. C and V pass through from flagsIn.
- R6: Ops 7 (shift left) and 8 (shift right) shift A and bring in a zero. The bit shifted out becomes C, Z and N follow the result, and write-back is asserted.
- R7: Ops 9 (rotate left) and 10 (rotate right) shift A and bring in carryIn at the vacated end. The bit shifted out becomes C. Z and N follow the result, and write-back is asserted.
- R8: Ops 11 (increment A) and 12 (decrement A) wrap modulo 256, update only Z and N, and assert write-back.
- R9: Op 13 (status load) sets flagsOut to B with bit 5 forced to 1 and bit 4 forced to 0. Write-back is deasserted.
- R10: Op codes 14 and 15 leave flagsOut equal to flagsIn and deassert write-back.
- R11: Status bits 2, 3, 4 and 5 pass through from flagsIn unchanged for every op except status load.
- R12: All outputs are a combinational function of the present inputs and are valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 4 | Operation select (codes 0 to 15) |
| operandA | input | 8 | Accumulator or index register operand |
| operandB | input | 8 | Memory or immediate operand |
| carryIn | input | 1 | Carry used by add, subtract and rotate |
| flagsIn | input | 8 | Current status byte |
| result | output | 8 | Operation result |
| flagsOut | output | 8 | Updated status byte |
| writeBack | output | 1 | Result is to be written to the register file |

## Verification
No register sits between inputs and outputs, so every result is due in the same cycle its stimulus is applied. The bench drives a new input set shortly after each rising edge and compares the outputs at the following falling edge. By then the combinational paths have settled, and no edge lies between the stimulus and the check. The reference model is a behavioural integer function of the op and operands. It is evaluated for the same input set at that falling edge, so no expected value is queued across cycles. The result is compared only when write-back is expected, and the flags and strobe are compared on every check.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FLAG_W = 8;
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_B = 4;
  localparam int FLAG_U = 5;
  localparam int FLAG_V = 6;
  localparam int FLAG_N = 7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_TEST = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_INC  = 4'd11,
    OP_DEC  = 4'd12,
    OP_PLF  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {ADDB_PLAIN, ADDB_INVERT, ADDB_ONE, ADDB_ONES} addSrc_e;
  typedef enum logic [1:0] {CIN_PORT, CIN_ZERO, CIN_ONE} cinSel_e;
  typedef enum logic [2:0] {RES_SUM, RES_AND, RES_OR, RES_XOR, RES_SHL, RES_SHR, RES_PASS} resSel_e;
  typedef enum logic [1:0] {CSEL_KEEP, CSEL_ADDER, CSEL_MSB, CSEL_LSB} carrySel_e;
  typedef enum logic [1:0] {VSEL_KEEP, VSEL_ADDER, VSEL_OPB} ovfSel_e;
  typedef enum logic [1:0] {ZN_KEEP, ZN_RESULT, ZN_TEST} znSel_e;

  typedef struct packed {
    addSrc_e   addSrc;
    cinSel_e   cinSel;
    resSel_e   resSel;
    logic      rotate;
    carrySel_e carrySel;
    ovfSel_e   ovfSel;
    znSel_e    znSel;
    logic      flagLoad;
    logic      writeBack;
  } aluStrobes_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [3:0]  opCode,
  output aluStrobes_t strobes
);

  aluOp_e opDec;
  assign opDec = aluOp_e'(opCode);

  always_comb begin
    strobes.addSrc    = ADDB_PLAIN;
    strobes.cinSel    = CIN_ZERO;
    strobes.resSel    = RES_PASS;
    strobes.rotate    = 1'b0;
    strobes.carrySel  = CSEL_KEEP;
    strobes.ovfSel    = VSEL_KEEP;
    strobes.znSel     = ZN_KEEP;
    strobes.flagLoad  = 1'b0;
    strobes.writeBack = 1'b0;
    unique case (opDec)
      OP_ADD: begin
        strobes.cinSel    = CIN_PORT;
        strobes.resSel    = RES_SUM;
        strobes.carrySel  = CSEL_ADDER;
        strobes.ovfSel    = VSEL_ADDER;
        strobes.znSel     = ZN_RESULT;
        strobes.writeBack = 1'b1;
      end
      OP_SUB: begin
        strobes.addSrc    = ADDB_INVERT;
        strobes.cinSel    = CIN_PORT;
        strobes.resSel    = RES_SUM;
        strobes.carrySel  = CSEL_ADDER;
        strobes.ovfSel    = VSEL_ADDER;
        strobes.znSel     = ZN_RESULT;
        strobes.writeBack = 1'b1;
      end
      OP_CMP: begin
        strobes.addSrc   = ADDB_INVERT;
        strobes.cinSel   = CIN_ONE;
        strobes.resSel   = RES_SUM;
        strobes.carrySel = CSEL_ADDER;
        strobes.znSel    = ZN_RESULT;
      end
      OP_AND, OP_OR, OP_XOR: begin
        strobes.resSel    = (opDec == OP_AND) ? RES_AND :
                            (opDec == OP_OR)  ? RES_OR  : RES_XOR;
        strobes.znSel     = ZN_RESULT;
        strobes.writeBack = 1'b1;
      end
      OP_TEST: begin
        strobes.resSel = RES_AND;
        strobes.ovfSel = VSEL_OPB;
        strobes.znSel  = ZN_TEST;
      end
      OP_SHL, OP_ROL: begin
        strobes.resSel    = RES_SHL;
        strobes.rotate    = (opDec == OP_ROL);
        strobes.carrySel  = CSEL_MSB;
        strobes.znSel     = ZN_RESULT;
        strobes.writeBack = 1'b1;
      end
      OP_SHR, OP_ROR: begin
        strobes.resSel    = RES_SHR;
        strobes.rotate    = (opDec == OP_ROR);
        strobes.carrySel  = CSEL_LSB;
        strobes.znSel     = ZN_RESULT;
        strobes.writeBack = 1'b1;
      end
      OP_INC, OP_DEC: begin
        strobes.addSrc    = (opDec == OP_INC) ? ADDB_ONE : ADDB_ONES;
        strobes.resSel    = RES_SUM;
        strobes.znSel     = ZN_RESULT;
        strobes.writeBack = 1'b1;
      end
      OP_PLF: begin
        strobes.flagLoad = 1'b1;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluStrobes_t       strobes,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic              carryIn,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsOut
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addOperand;
  logic              cinBit;
  logic [DATA_W:0]   sumWide;
  logic              shiftIn;
  logic [DATA_W-1:0] shlVal;
  logic [DATA_W-1:0] shrVal;
  logic [DATA_W-1:0] andVal;
  logic              adderOvf;

  always_comb begin
    unique case (strobes.addSrc)
      ADDB_PLAIN:  addOperand = operandB;
      ADDB_INVERT: addOperand = ~operandB;
      ADDB_ONE:    addOperand = {{(DATA_W-1){1'b0}}, 1'b1};
      default:     addOperand = {DATA_W{1'b1}};
    endcase
  end

  always_comb begin
    unique case (strobes.cinSel)
      CIN_PORT: cinBit = carryIn;
      CIN_ONE:  cinBit = 1'b1;
      default:  cinBit = 1'b0;
    endcase
  end

  assign sumWide  = {1'b0, operandA} + {1'b0, addOperand} + {{DATA_W{1'b0}}, cinBit};
  assign adderOvf = (operandA[MSB] == addOperand[MSB]) && (sumWide[MSB] != operandA[MSB]);

  assign shiftIn = strobes.rotate & carryIn;
  assign shlVal  = {operandA[MSB-1:0], shiftIn};
  assign shrVal  = {shiftIn, operandA[MSB:1]};
  assign andVal  = operandA & operandB;

  always_comb begin
    unique case (strobes.resSel)
      RES_SUM: result = sumWide[MSB:0];
      RES_AND: result = andVal;
      RES_OR:  result = operandA | operandB;
      RES_XOR: result = operandA ^ operandB;
      RES_SHL: result = shlVal;
      RES_SHR: result = shrVal;
      default: result = operandA;
    endcase
  end

  always_comb begin
    flagsOut = flagsIn;
    unique case (strobes.carrySel)
      CSEL_ADDER: flagsOut[FLAG_C] = sumWide[DATA_W];
      CSEL_MSB:   flagsOut[FLAG_C] = operandA[MSB];
      CSEL_LSB:   flagsOut[FLAG_C] = operandA[0];
      default:    flagsOut[FLAG_C] = flagsIn[FLAG_C];
    endcase
    unique case (strobes.ovfSel)
      VSEL_ADDER: flagsOut[FLAG_V] = adderOvf;
      VSEL_OPB:   flagsOut[FLAG_V] = operandB[MSB-1];
      default:    flagsOut[FLAG_V] = flagsIn[FLAG_V];
    endcase
    unique case (strobes.znSel)
      ZN_RESULT: begin
        flagsOut[FLAG_Z] = (result == '0);
        flagsOut[FLAG_N] = result[MSB];
      end
      ZN_TEST: begin
        flagsOut[FLAG_Z] = (andVal == '0);
        flagsOut[FLAG_N] = operandB[MSB];
      end
      default: begin
        flagsOut[FLAG_Z] = flagsIn[FLAG_Z];
        flagsOut[FLAG_N] = flagsIn[FLAG_N];
      end
    endcase
    if (strobes.flagLoad) begin
      flagsOut         = operandB[FLAG_W-1:0];
      flagsOut[FLAG_U] = 1'b1;
      flagsOut[FLAG_B] = 1'b0;
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic              carryIn,
  input  logic [7:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flagsOut,
  output logic              writeBack
);

  aluStrobes_t strobes;

  alu8_ctrl u_ctrl (
    .opCode  (opCode),
    .strobes (strobes)
  );

  alu8_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobes  (strobes),
    .operandA (operandA),
    .operandB (operandB),
    .carryIn  (carryIn),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsOut (flagsOut)
  );

  assign writeBack = strobes.writeBack;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DATA_W = 8
) (
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] operandA,
  input logic [DATA_W-1:0] operandB,
  input logic              carryIn,
  input logic [7:0]        flagsIn,
  input logic [DATA_W-1:0] result,
  input logic [7:0]        flagsOut,
  input logic              writeBack
);

  always_comb begin
    // R3: compare never writes back, carry is the unsigned ordering
    if (opCode == 4'd2) begin
      assert_cmp_nowb_R3: assert (!writeBack && flagsOut[0] == (operandA >= operandB));
    end
    // R5: logic ops keep carry and overflow
    if (opCode == 4'd3 || opCode == 4'd4 || opCode == 4'd5) begin
      assert_logic_keep_cv_R5: assert (flagsOut[0] == flagsIn[0] && flagsOut[6] == flagsIn[6]);
    end
    // R8: increment and decrement keep carry and overflow
    if (opCode == 4'd11 || opCode == 4'd12) begin
      assert_incdec_keep_cv_R8: assert (flagsOut[0] == flagsIn[0] && flagsOut[6] == flagsIn[6]);
    end
    // R9: status load forces bit 5 high and bit 4 low
    if (opCode == 4'd13) begin
      assert_plf_bits_R9: assert (flagsOut[5] && !flagsOut[4] && !writeBack);
    end
    // R10: reserved codes change nothing
    if (opCode >= 4'd14) begin
      assert_rsv_noop_R10: assert (flagsOut == flagsIn && !writeBack);
    end
    // R11: bits 2..5 pass through except on status load
    if (opCode != 4'd13) begin
      assert_mid_bits_pass_R11: assert (flagsOut[5:2] == flagsIn[5:2]);
    end
    // R1: a written-back result always carries a matching Z flag
    if (writeBack) begin
      assert_zero_match_R1: assert (flagsOut[1] == (result == '0));
    end
  end

endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

  localparam time CLK_HALF = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] operandA = '0;
  logic [7:0] operandB = '0;
  logic       carryIn = 1'b0;
  logic [7:0] flagsIn = '0;
  logic [7:0] result;
  logic [7:0] flagsOut;
  logic       writeBack;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #CLK_HALF clk = ~clk;

  alu8_core u_dut (
    .opCode    (opCode),
    .operandA  (operandA),
    .operandB  (operandB),
    .carryIn   (carryIn),
    .flagsIn   (flagsIn),
    .result    (result),
    .flagsOut  (flagsOut),
    .writeBack (writeBack)
  );

  function automatic string reqOf(int op);
    case (op)
      0: return "R1";   1: return "R2";   2: return "R3";
      3, 4, 5: return "R5";             6: return "R4";
      7, 8: return "R6"; 9, 10: return "R7"; 11, 12: return "R8";
      13: return "R9";  default: return "R10";
    endcase
  endfunction

  // behavioural reference: {wb, flags, result}
  function automatic logic [16:0] model(int op, int a, int b, int c, int f);
    int r = a; int fl = f; int wb = 0; int s;
    bit zn = 0;
    case (op)
      0: begin s = a + b + c; r = s & 255; fl = (fl & ~1) | ((s >> 8) & 1);
           fl = (fl & ~64) | ((((a ^ b) & 128) == 0 && ((a ^ r) & 128) != 0) ? 64 : 0);
           zn = 1; wb = 1; end
      1: begin s = a - b - (1 - c); r = s & 255; fl = (fl & ~1) | (s >= 0 ? 1 : 0);
           fl = (fl & ~64) | ((((a ^ b) & 128) != 0 && ((a ^ r) & 128) != 0) ? 64 : 0);
           zn = 1; wb = 1; end
      2: begin r = (a - b) & 255; fl = (fl & ~1) | (a >= b ? 1 : 0); zn = 1; end
      3: begin r = a & b; zn = 1; wb = 1; end
      4: begin r = a | b; zn = 1; wb = 1; end
      5: begin r = a ^ b; zn = 1; wb = 1; end
      6: begin fl = fl & ~(2 | 64 | 128);
           fl = fl | (((a & b) == 0) ? 2 : 0) | (b & 192); end
      7: begin r = (a << 1) & 255; fl = (fl & ~1) | (a >> 7); zn = 1; wb = 1; end
      8: begin r = a >> 1; fl = (fl & ~1) | (a & 1); zn = 1; wb = 1; end
      9: begin r = ((a << 1) | c) & 255; fl = (fl & ~1) | (a >> 7); zn = 1; wb = 1; end
      10: begin r = (a >> 1) | (c << 7); fl = (fl & ~1) | (a & 1); zn = 1; wb = 1; end
      11: begin r = (a + 1) & 255; zn = 1; wb = 1; end
      12: begin r = (a + 255) & 255; zn = 1; wb = 1; end
      13: fl = (b | 32) & ~16;
      default: ;
    endcase
    if (zn) fl = (fl & ~(2 | 128)) | (r == 0 ? 2 : 0) | (r & 128);
    return {wb[0], fl[7:0], r[7:0]};
  endfunction

  // R12: drive after a rising edge, check at the following falling edge (same cycle)
  task automatic apply(int op, int a, int b, int c, int f);
    logic [16:0] exp;
    @(posedge clk);
    #2ns;
    opCode = op[3:0]; operandA = a[7:0]; operandB = b[7:0];
    carryIn = c[0]; flagsIn = f[7:0];
    @(negedge clk);
    exp = model(op, a, b, c, f);
    testsRun++;
    if (writeBack !== exp[16] || flagsOut !== exp[15:8] ||
        (exp[16] && result !== exp[7:0])) begin
      testsFailed++;
      $display("FAIL %s R12 op=%0d a=%02h b=%02h c=%0d f=%02h: got wb=%0d flags=%02h res=%02h, expected wb=%0d flags=%02h res=%02h",
               reqOf(op), op, a, b, c, f, writeBack, flagsOut, result, exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  initial begin : watchdog
    #(200000 * 2 * CLK_HALF);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    // reset state: zero inputs mean add 0+0, Z set, write-back (R1)
    @(negedge clk);
    testsRun++;
    if (writeBack !== 1'b1 || flagsOut !== 8'h02 || result !== 8'h00) begin
      testsFailed++;
      $display("FAIL R1 reset: got wb=%0d flags=%02h res=%02h, expected wb=1 flags=02 res=00",
               writeBack, flagsOut, result);
    end
    rstN = 1'b1;
    // R1 signed overflow into negative, and carry out to zero
    apply(0, 8'h7F, 8'h01, 0, 8'h00);
    apply(0, 8'hFF, 8'h01, 0, 8'hC1);
    apply(0, 8'h80, 8'h80, 1, 8'h00);
    // R2 borrow, signed overflow, and no-borrow with carry clear
    apply(1, 8'h50, 8'h70, 1, 8'h00);
    apply(1, 8'h80, 8'h01, 1, 8'h00);
    apply(1, 8'h05, 8'h04, 0, 8'h40);
    // R3 equal, less, greater; V preserved
    apply(2, 8'h42, 8'h42, 0, 8'h40);
    apply(2, 8'h10, 8'h20, 1, 8'h01);
    apply(2, 8'hF0, 8'h0F, 0, 8'h00);
    // R4 bit test
    apply(6, 8'h3F, 8'hC0, 1, 8'h01);
    apply(6, 8'hFF, 8'h01, 0, 8'hC0);
    // R5 logic ops keep C and V
    apply(3, 8'hF0, 8'h0F, 1, 8'h41);
    apply(4, 8'h00, 8'h00, 0, 8'hC1);
    apply(5, 8'hAA, 8'h2A, 1, 8'h41);
    // R6 shifts bring in zero even with carry set
    apply(7, 8'h80, 8'h00, 1, 8'h00);
    apply(8, 8'h01, 8'h00, 1, 8'h00);
    // R7 rotates bring in carry
    apply(9, 8'h40, 8'h00, 1, 8'h00);
    apply(10, 8'h02, 8'h00, 1, 8'h01);
    // R8 wrap
    apply(11, 8'hFF, 8'h00, 0, 8'h41);
    apply(12, 8'h00, 8'h00, 1, 8'h00);
    // R9 status load
    apply(13, 8'h00, 8'h10, 0, 8'hFF);
    apply(13, 8'h00, 8'hEF, 1, 8'h00);
    // R10 reserved codes, R11 middle bits
    apply(14, 8'h12, 8'h34, 1, 8'hA5);
    apply(15, 8'h00, 8'hFF, 0, 8'h3C);
    // random sweep over every op
    for (int i = 0; i < 4000; i++) begin
      apply(int'($urandom_range(15, 0)), int'($urandom_range(255, 0)),
            int'($urandom_range(255, 0)), int'($urandom_range(1, 0)),
            int'($urandom_range(255, 0)));
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule